// File: doc/BRIEF.md
# Two-Level Arrival-Order Bus Arbiter

This block decides which of fourteen bus modules may take the bus next. Each module drives two request bits, one urgent and one normal. Within each of the two levels the arbiter serves requests in the order they arrived, and the module's position on the port carries no weight. Normal requests are served only while no urgent request is raised anywhere. At most one grant is active at a time. A grant stays with its owner until that module drops both of its request bits.

A system controller gates the issue of new grants with an enable input and a separate inhibit input, which is meant for a bus-initialisation sequence. Neither input can take back a grant already given. The arbiter also raises a preemption hint so that the current owner knows others are waiting. A mode input picks how that hint is computed. The request inputs are expected to be synchronous to the arbiter clock already.

Top module: `tier_arbiter`

## Requirements
- R1: `grant` is one-hot or zero. Bit n of `grant` belongs to module n, whose requests are `req_hi[n]` and `req_lo[n]`.
- R2: Within one level, the request that has been raised the longest is granted first, whatever its index. Requests that first appear in the same cycle are ordered lowest index first.
- R3: A `req_lo` request is granted only in a cycle in which every bit of `req_hi` is 0.
- R4: An active grant for module n holds while `req_hi[n]` or `req_lo[n]` is 1. `grant` returns to zero one cycle after both bits are 0. The next grant is issued no earlier than the cycle after that.
- R5: A new grant is issued only while `grant_en` is 1 and `grant_inhibit` is 0. Lowering `grant_en` or raising `grant_inhibit` does not remove an active grant.
- R6: `any_grant` is 1 exactly when some bit of `grant` is 1.
- R7: With `prio_preempt` = 1, `preempt` is 1 when a grant is active and some module without the grant holds `req_hi` = 1. Otherwise it is 0.
- R8: With `prio_preempt` = 0, `preempt` is 1 when two or more modules hold at least one request bit. A module raising both of its bits counts once.
- R9: A request dropped before its grant leaves the queue and is never granted. Only a module whose request was 1 in the previous cycle can receive a new grant.
- R10: While `rst_n` is 0, `grant` and `any_grant` are 0 and both queues are empty.
- R11: Suppose the arbiter is idle and enabled, and a request is raised in cycle c. Its grant then appears in cycle c+2, because the request enters the age queue first and the grant is registered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hi | input | NMOD | Urgent request per module |
| req_lo | input | NMOD | Normal request per module |
| grant_en | input | 1 | 1 allows new grants |
| grant_inhibit | input | 1 | 1 blocks new grants |
| prio_preempt | input | 1 | Preemption policy: 1 = unserved-urgent rule, 0 = multiple-requester rule |
| grant | output | NMOD | One-hot grant |
| any_grant | output | 1 | 1 while a grant is active |
| preempt | output | 1 | Preemption hint |

## Verification
The assertions assume that requests are synchronous bits that may rise or fall in any cycle. They also assume that a module which owns the grant eventually releases both of its request bits. The bench keeps to this: it changes inputs only just after a clock edge, and it always lowers both request bits of the module it serves. The assertions do not assume that requests stay up until they are granted. The bench withdraws a request on purpose to exercise R9.

// File: rtl/tier_arb_pkg.sv
`timescale 1ns/1ps
package tier_arb_pkg;
   // request levels, the value doubles as the queue instance index
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } level_e;

   localparam int unsigned NUM_LEVELS = 2;
endpackage

// File: rtl/tier_age_queue.sv
`timescale 1ns/1ps
// Arrival-ordered list of module indices for one request level.
module tier_age_queue #(
   parameter int unsigned NMOD = 14,
   localparam int unsigned IDXW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NMOD-1:0] req,
   output logic [IDXW-1:0] head_idx,
   output logic            head_vld
);
   logic [IDXW-1:0] slot_idx   [NMOD];
   logic [NMOD-1:0] slot_vld;
   logic [NMOD-1:0] member_q;      // modules currently held in the list

   logic [IDXW-1:0] nxt_idx    [NMOD];
   logic [NMOD-1:0] nxt_vld;
   logic [NMOD-1:0] arrivals;
   logic [IDXW-1:0] wr_ptr;
   logic            seen;
   logic [IDXW-1:0] oldest;

   always_comb begin
      for (int k = 0; k < NMOD; k++) nxt_idx[k] = '0;
      nxt_vld  = '0;
      wr_ptr   = '0;
      seen     = 1'b0;
      oldest   = '0;
      arrivals = req & ~member_q;
      // survivors keep their relative age and slide toward slot 0
      for (int i = 0; i < NMOD; i++) begin
         if (slot_vld[i] && req[slot_idx[i]]) begin
            nxt_idx[wr_ptr] = slot_idx[i];
            nxt_vld[wr_ptr] = 1'b1;
            if (!seen) begin
               seen   = 1'b1;
               oldest = slot_idx[i];
            end
            wr_ptr = wr_ptr + IDXW'(1);
         end
      end
      // newcomers of this cycle go behind, lowest index first
      for (int j = 0; j < NMOD; j++) begin
         if (arrivals[j]) begin
            nxt_idx[wr_ptr] = IDXW'(j);
            nxt_vld[wr_ptr] = 1'b1;
            wr_ptr = wr_ptr + IDXW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NMOD; k++) slot_idx[k] <= '0;
         slot_vld <= '0;
         member_q <= '0;
      end else begin
         for (int k = 0; k < NMOD; k++) slot_idx[k] <= nxt_idx[k];
         slot_vld <= nxt_vld;
         member_q <= req;
      end
   end

   assign head_idx = oldest;
   assign head_vld = seen;
endmodule

// File: rtl/tier_grant_ctl.sv
`timescale 1ns/1ps
// Holds the single active grant and picks the next owner.
module tier_grant_ctl #(
   parameter int unsigned NMOD = 14,
   localparam int unsigned IDXW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NMOD-1:0] req_hi,
   input  logic [NMOD-1:0] req_lo,
   input  logic [IDXW-1:0] hi_head,
   input  logic            hi_head_vld,
   input  logic [IDXW-1:0] lo_head,
   input  logic            lo_head_vld,
   input  logic            issue_ok,
   output logic [NMOD-1:0] gnt
);
   logic [NMOD-1:0] gnt_q, gnt_d;
   logic            owner_busy;
   logic            hi_any;

   assign owner_busy = |(gnt_q & (req_hi | req_lo));
   assign hi_any     = |req_hi;

   always_comb begin
      gnt_d = '0;
      if (gnt_q != '0) begin
         if (owner_busy) gnt_d = gnt_q;
      end else if (issue_ok) begin
         if (hi_any) begin
            if (hi_head_vld) gnt_d[hi_head] = 1'b1;
         end else if (lo_head_vld) begin
            gnt_d[lo_head] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   assign gnt = gnt_q;
endmodule

// File: rtl/tier_preempt_eval.sv
`timescale 1ns/1ps
// Preemption hint, two policies selected at run time.
module tier_preempt_eval #(
   parameter int unsigned NMOD = 14
) (
   input  logic [NMOD-1:0] req_hi,
   input  logic [NMOD-1:0] req_lo,
   input  logic [NMOD-1:0] gnt,
   input  logic            prio_mode,
   output logic            preempt
);
   logic [NMOD-1:0] per_module;
   logic            urgent_waiting;
   logic            crowded;

   assign per_module     = req_hi | req_lo;
   assign urgent_waiting = (gnt != '0) && ((req_hi & ~gnt) != '0);
   assign crowded        = $countones(per_module) > 1;
   assign preempt        = prio_mode ? urgent_waiting : crowded;
endmodule

// File: rtl/tier_arbiter.sv
`timescale 1ns/1ps
module tier_arbiter #(
   parameter int unsigned NMOD = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NMOD-1:0] req_hi,
   input  logic [NMOD-1:0] req_lo,
   input  logic            grant_en,
   input  logic            grant_inhibit,
   input  logic            prio_preempt,
   output logic [NMOD-1:0] grant,
   output logic            any_grant,
   output logic            preempt
);
   import tier_arb_pkg::*;

   localparam int unsigned IDXW = (NMOD > 1) ? $clog2(NMOD) : 1;

   if (NMOD < 2 || NMOD > 64) begin : g_bad_nmod
      $error("tier_arbiter: NMOD must lie in 2..64");
   end

   logic [NMOD-1:0] lvl_req  [NUM_LEVELS];
   logic [IDXW-1:0] lvl_head [NUM_LEVELS];
   logic [NUM_LEVELS-1:0] lvl_vld;

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
      assign lvl_req[l] = (l == int'(LVL_HIGH)) ? req_hi : req_lo;
      tier_age_queue #(.NMOD(NMOD)) u_queue (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (lvl_req[l]),
         .head_idx (lvl_head[l]),
         .head_vld (lvl_vld[l])
      );
   end

   tier_grant_ctl #(.NMOD(NMOD)) u_grant (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_hi      (req_hi),
      .req_lo      (req_lo),
      .hi_head     (lvl_head[int'(LVL_HIGH)]),
      .hi_head_vld (lvl_vld[int'(LVL_HIGH)]),
      .lo_head     (lvl_head[int'(LVL_LOW)]),
      .lo_head_vld (lvl_vld[int'(LVL_LOW)]),
      .issue_ok    (grant_en && !grant_inhibit),
      .gnt         (grant)
   );

   tier_preempt_eval #(.NMOD(NMOD)) u_preempt (
      .req_hi    (req_hi),
      .req_lo    (req_lo),
      .gnt       (grant),
      .prio_mode (prio_preempt),
      .preempt   (preempt)
   );

   assign any_grant = |grant;
endmodule

// File: rtl/tier_arbiter_chk.sv
`timescale 1ns/1ps
module tier_arbiter_chk #(
   parameter int unsigned NMOD = 14
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NMOD-1:0] req_hi,
   input logic [NMOD-1:0] req_lo,
   input logic            grant_en,
   input logic            grant_inhibit,
   input logic [NMOD-1:0] grant
);
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_low_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && req_hi != '0) |=> (grant == '0 || (grant & $past(req_hi)) != '0));

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && (grant & (req_hi | req_lo)) != '0) |=> grant == $past(grant));

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && (grant & (req_hi | req_lo)) == '0) |=> grant == '0);

   p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && (!grant_en || grant_inhibit)) |=> grant == '0);

   p_live_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant == '0 |=> (grant & ~($past(req_hi) | $past(req_lo))) == '0);
endmodule

bind tier_arbiter tier_arbiter_chk #(.NMOD(NMOD)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_hi        (req_hi),
   .req_lo        (req_lo),
   .grant_en      (grant_en),
   .grant_inhibit (grant_inhibit),
   .grant         (grant)
);

// File: tb/tier_arbiter_bench.sv
`timescale 1ns/1ps
module tier_arbiter_bench;
   localparam int N = 14;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] req_hi, req_lo;
   logic         grant_en, grant_inhibit, prio_preempt;
   logic [N-1:0] grant;
   logic         any_grant, preempt;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   int exp_q[$];
   logic [N-1:0] prev_g = '0;

   always #10 clk = ~clk;   // 50 MHz

   tier_arbiter #(.NMOD(N)) u_tier_arbiter (
      .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
      .grant_en(grant_en), .grant_inhibit(grant_inhibit),
      .prio_preempt(prio_preempt), .grant(grant),
      .any_grant(any_grant), .preempt(preempt));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // wait for module n to own the bus, then let it go
   task automatic serve(input int n);
      int waited = 0;
      while (!grant[n] && waited < 20) begin
         tick();
         waited++;
      end
      chk(grant[n] == 1'b1, "R2 serve order", longint'(grant), longint'(1) << n);
      req_hi[n] = 1'b0;
      req_lo[n] = 1'b0;
      tick();
   endtask

   // scoreboard monitor: every fresh grant is compared with the next expected owner
   always @(negedge clk) begin
      if (rst_n && grant != '0 && grant != prev_g) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected grant", longint'(grant), 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(grant == (N'(1) << e), "R1 R2 R3 grant owner", longint'(grant), longint'(1) << e);
         end
      end
      prev_g <= grant;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         vectors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_hi = '0; req_lo = '0;
      grant_en = 1'b1; grant_inhibit = 1'b0; prio_preempt = 1'b0;
      repeat (3) tick();
      chk(grant == '0 && !any_grant, "R10 reset", longint'(grant), 0);
      rst_n = 1'b1;
      tick();

      // latency and any-grant
      exp_q.push_back(5);
      req_hi[5] = 1'b1;
      tick();
      chk(grant == '0, "R11 not yet", longint'(grant), 0);
      tick();
      chk(grant == N'(1) << 5, "R11 grant at c+2", longint'(grant), longint'(1) << 5);
      chk(any_grant == 1'b1, "R6 any_grant set", longint'(any_grant), 1);

      // preemption policies
      req_lo[5] = 1'b1;
      #1 chk(preempt == 1'b0, "R8 dual request counts once", longint'(preempt), 0);
      req_lo[9] = 1'b1;
      tick();
      chk(preempt == 1'b1, "R8 two modules", longint'(preempt), 1);
      prio_preempt = 1'b1;
      #1 chk(preempt == 1'b0, "R7 only normal waiting", longint'(preempt), 0);

      // arrival order, index irrelevant
      req_hi[11] = 1'b1;
      tick();
      chk(preempt == 1'b1, "R7 urgent waiting", longint'(preempt), 1);
      req_hi[2] = 1'b1;
      tick();
      req_hi[7] = 1'b1; req_hi[3] = 1'b1;
      tick(); tick();
      chk(grant == N'(1) << 5, "R4 held", longint'(grant), longint'(1) << 5);
      exp_q.push_back(11); exp_q.push_back(2); exp_q.push_back(3);
      exp_q.push_back(7);  exp_q.push_back(9);
      req_hi[5] = 1'b0;
      tick();
      chk(grant == N'(1) << 5, "R4 held by low bit", longint'(grant), longint'(1) << 5);
      req_lo[5] = 1'b0;
      tick();
      chk(grant == '0, "R4 released", longint'(grant), 0);
      chk(any_grant == 1'b0, "R6 any_grant clear", longint'(any_grant), 0);
      tick();
      chk(grant == N'(1) << 11, "R2 oldest first", longint'(grant), longint'(1) << 11);
      serve(11); serve(2); serve(3); serve(7); serve(9);
      tick();
      chk(grant == '0, "R4 idle after drain", longint'(grant), 0);

      // enable and inhibit
      grant_en = 1'b0;
      exp_q.push_back(4);
      req_hi[4] = 1'b1;
      repeat (4) tick();
      chk(grant == '0, "R5 disabled", longint'(grant), 0);
      grant_en = 1'b1; grant_inhibit = 1'b1;
      repeat (3) tick();
      chk(grant == '0, "R5 inhibited", longint'(grant), 0);
      grant_inhibit = 1'b0;
      tick();
      chk(grant == N'(1) << 4, "R5 issued", longint'(grant), longint'(1) << 4);
      grant_en = 1'b0;
      tick(); tick();
      chk(grant == N'(1) << 4, "R5 kept while disabled", longint'(grant), longint'(1) << 4);
      req_hi[6] = 1'b1; req_hi[4] = 1'b0;
      repeat (3) tick();
      chk(grant == '0, "R5 no new grant", longint'(grant), 0);
      exp_q.push_back(6);
      grant_en = 1'b1;
      tick();
      chk(grant == N'(1) << 6, "R5 re-enabled", longint'(grant), longint'(1) << 6);
      chk(preempt == 1'b0, "R7 no contender", longint'(preempt), 0);
      serve(6);

      // withdrawal
      grant_en = 1'b0;
      req_hi[1] = 1'b1; req_hi[8] = 1'b1;
      tick(); tick();
      req_hi[1] = 1'b0;
      tick();
      exp_q.push_back(8);
      grant_en = 1'b1;
      tick();
      chk(grant == N'(1) << 8, "R9 skip withdrawn", longint'(grant), longint'(1) << 8);
      serve(8);
      repeat (4) tick();
      chk(grant == '0, "R9 never granted", longint'(grant), 0);

      // normal-level grant with urgent contender
      exp_q.push_back(10);
      req_lo[10] = 1'b1;
      tick(); tick();
      chk(grant == N'(1) << 10, "R3 normal granted when idle", longint'(grant), longint'(1) << 10);
      req_hi[12] = 1'b1;
      #1 chk(preempt == 1'b1, "R7 urgent over normal grant", longint'(preempt), 1);
      prio_preempt = 1'b0;
      #1 chk(preempt == 1'b1, "R8 two modules", longint'(preempt), 1);
      req_hi[12] = 1'b0;
      #1 chk(preempt == 1'b0, "R8 single module", longint'(preempt), 0);
      serve(10);

      // level priority against older normal request
      grant_en = 1'b0;
      req_lo[0] = 1'b1;
      tick();
      req_hi[13] = 1'b1;
      tick();
      exp_q.push_back(13); exp_q.push_back(0);
      grant_en = 1'b1;
      serve(13); serve(0);

      // same-cycle arrivals
      grant_en = 1'b0;
      req_hi[9] = 1'b1; req_hi[1] = 1'b1;
      tick();
      exp_q.push_back(1); exp_q.push_back(9);
      grant_en = 1'b1;
      serve(1); serve(9);
      tick();

      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule